// File: doc/BRIEF.md
# Dual-Channel Looping Command Sequencer

This block steps two command engines, one for the write side and one for the read side, through short command lists that software loads into two small internal stores. Each list entry carries a valid flag, an optional dependency on a write-list index and a 16-bit payload. A valid entry is offered on that channel's ready/valid issue port. The downstream agent returns a completion pulse for every accepted command. The block does not build bus transactions. It only decides what is issued and when.

Software controls the block through one 32-bit control/status word. That word holds a fixed revision byte, a read-only code for the configured ID width, a start bit that clears itself and a loop bit. With the loop bit set, each channel wraps to its own entry 0 as soon as it reaches the end of its list. It does not wait for the other channel or for outstanding completions, and read dependencies are ignored. After the loop bit is cleared, each channel finishes the pass it is in and stops. The start bit then falls once both channels have drained, and a level interrupt is raised if interrupts are enabled.

Top module: `cmd_seq_top`

## Requirements
- R1: Reading the control word gives 0x20 in bits 31:24. Bits 23:21 give the ID-width code: 0 for a width of 0 or 1 bit, otherwise the width minus 1 (4 bits gives code 3). Bits 18:0 read zero. Writes to any of these bits have no effect.
- R2: Bit 19 (loop) can be written and read back at any time.
- R3: Writing 1 to bit 20 while it reads 0 starts both channels at entry 0. The bit reads 1 until both channels have ended their pass and received every completion, and then it clears by itself. A write of 1 while the bit is already 1 is ignored.
- R4: A store entry is 22 bits. Bit 21 is valid, bit 20 is the dependency enable, bits 19:16 are the write index depended on, and bits 15:0 are the payload. A channel offers its valid entries in index order with the entry index and payload, and holds each offer until it is accepted.
- R5: A pass ends at the first entry with bit 21 clear, or after entry 15 if all 16 entries are valid.
- R6: In a read pass that started with loop at 0, a read entry with the dependency enabled is not offered until the completion for the named write index has been returned during this run.
- R7: While loop is 1, each channel restarts at entry 0 after the end of its list without waiting for completions or for the other channel, and read dependencies are ignored.
- R8: After loop is cleared, each channel completes its current pass and then stops, so a channel never stops in the middle of a pass.
- R9: When a run ends with irq_en high, irq rises and stays high until an irq_clr pulse. With irq_en low, irq stays low.
- R10: Writes to the command stores are ignored while bit 20 reads 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| csr_wr | input | 1 | Control word write strobe |
| csr_wdata | input | 32 | Control word write data |
| csr_rdata | output | 32 | Control word read value |
| irq_en | input | 1 | Allows the end-of-run interrupt |
| irq_clr | input | 1 | Pulse that clears irq |
| irq | output | 1 | Level end-of-run interrupt |
| cmd_we | input | 1 | Command store write strobe |
| cmd_bank | input | 1 | Store select: 0 write list, 1 read list |
| cmd_addr | input | 4 | Store entry address |
| cmd_wdata | input | 22 | Store entry data |
| wr_cmd_vld | output | 1 | Write command offered |
| wr_cmd_rdy | input | 1 | Write command accepted |
| wr_cmd_idx | output | 4 | Index of offered write command |
| wr_cmd_payload | output | 16 | Payload of offered write command |
| wr_done | input | 1 | Write completion pulse |
| wr_done_idx | input | 4 | Index of the completed write |
| rd_cmd_vld | output | 1 | Read command offered |
| rd_cmd_rdy | input | 1 | Read command accepted |
| rd_cmd_idx | output | 4 | Index of offered read command |
| rd_cmd_payload | output | 16 | Payload of offered read command |
| rd_done | input | 1 | Read completion pulse |

## Verification
Most internal faults show up at the issue ports within a few cycles of the start write. A pointer that is wrong or not advancing produces payloads out of order or a wrong issue count. A faulty end-of-list test produces extra or missing issues, and with loop set it changes how often the short list repeats relative to the long one. Faults in dependency or completion tracking move the first read offer to before the tracked write completion, or stall it forever. A stuck run state leaves bit 20 at 1 and irq low, which the bench catches with its end-of-run timeout.

// File: rtl/cmd_seq_pkg.sv
package cmd_seq_pkg;
  parameter int unsigned CS_DEPTH = 16;
  parameter int unsigned CS_PAY_W = 16;
  parameter int unsigned CS_CSR_W = 32;
  localparam int unsigned CS_IDX_W = $clog2(CS_DEPTH);
  localparam int unsigned CS_PTR_W = $clog2(CS_DEPTH + 1);
  localparam int unsigned CS_ENT_W = CS_PAY_W + CS_IDX_W + 2;
  localparam logic [7:0]  CS_REV   = 8'h20;
  localparam int unsigned CS_EN_BIT   = 20;
  localparam int unsigned CS_LOOP_BIT = 19;
  localparam int unsigned CS_RSV_W    = CS_LOOP_BIT;

  typedef struct packed {
    logic                valid;
    logic                dep_en;
    logic [CS_IDX_W-1:0] dep_idx;
    logic [CS_PAY_W-1:0] payload;
  } cmd_entry_t;

  typedef enum logic [1:0] {
    CH_IDLE  = 2'd0,
    CH_RUN   = 2'd1,
    CH_DRAIN = 2'd2,
    CH_FIN   = 2'd3
  } chan_state_e;
endpackage

// File: rtl/cmd_store.sv
module cmd_store
  import cmd_seq_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                we,
  input  logic [CS_IDX_W-1:0] waddr,
  input  cmd_entry_t          wdata,
  input  logic [CS_PTR_W-1:0] raddr,
  output cmd_entry_t          rdata
);
  cmd_entry_t mem_q [CS_DEPTH];

  for (genvar e = 0; e < CS_DEPTH; e++) begin : g_ent
    logic ent_we;
    assign ent_we = we && (waddr == CS_IDX_W'(e));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        mem_q[e] <= '0;
      end else if (ent_we) begin
        mem_q[e] <= wdata;
      end
    end
  end

  always_comb begin
    if (int'(raddr) < CS_DEPTH) begin
      rdata = mem_q[raddr[CS_IDX_W-1:0]];
    end else begin
      rdata = '0;
    end
  end
endmodule

// File: rtl/cmp_track.sv
module cmp_track
  import cmd_seq_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clr_all,
  input  logic                issue,
  input  logic [CS_IDX_W-1:0] issue_idx,
  input  logic                done,
  input  logic [CS_IDX_W-1:0] done_idx,
  output logic [CS_DEPTH-1:0] cmp_vec
);
  logic [CS_DEPTH-1:0] vec_q, vec_d;

  always_comb begin
    vec_d = vec_q;
    if (clr_all) begin
      vec_d = '0;
    end else begin
      if (issue) vec_d[issue_idx] = 1'b0;
      if (done)  vec_d[done_idx]  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vec_q <= '0;
    else        vec_q <= vec_d;
  end

  assign cmp_vec = vec_q;
endmodule

// File: rtl/cmd_chan.sv
module cmd_chan
  import cmd_seq_pkg::*;
#(
  parameter int unsigned MAX_OUT = 16,
  parameter bit          DEP_EN  = 1'b0
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic                loop_on,
  input  logic                loop_at_start,
  input  logic                release_i,
  input  cmd_entry_t          entry,
  input  logic [CS_DEPTH-1:0] dep_vec,
  input  logic                rdy,
  input  logic                done,
  output logic [CS_PTR_W-1:0] ptr,
  output logic                vld,
  output logic                issue,
  output logic                fin
);
  localparam int unsigned OUT_W = $clog2(MAX_OUT + 1);

  chan_state_e         st_q, st_d;
  logic [CS_PTR_W-1:0] ptr_q, ptr_d;
  logic [OUT_W-1:0]    out_q, out_d;
  logic                dep_on_q, dep_on_d;
  logic                blocked, full, done_ok;

  assign blocked = dep_on_q && entry.dep_en && !dep_vec[entry.dep_idx];
  assign full    = (out_q == OUT_W'(MAX_OUT));
  assign vld     = (st_q == CH_RUN) && entry.valid && !blocked && !full;
  assign issue   = vld && rdy;
  assign done_ok = done && (out_q != '0);
  assign fin     = (st_q == CH_FIN);
  assign ptr     = ptr_q;

  always_comb begin
    st_d     = st_q;
    ptr_d    = ptr_q;
    dep_on_d = dep_on_q;
    unique case (st_q)
      CH_IDLE: begin
        if (start) begin
          st_d     = CH_RUN;
          ptr_d    = '0;
          dep_on_d = DEP_EN && !loop_at_start;
        end
      end
      CH_RUN: begin
        if (issue) begin
          ptr_d = ptr_q + 1'b1;
        end else if (!entry.valid) begin
          if (loop_on) begin
            ptr_d    = '0;
            dep_on_d = 1'b0;
          end else begin
            st_d = CH_DRAIN;
          end
        end
      end
      CH_DRAIN: begin
        if (out_q == '0) st_d = CH_FIN;
      end
      CH_FIN: begin
        if (release_i) st_d = CH_IDLE;
      end
      default: st_d = CH_IDLE;
    endcase
  end

  always_comb begin
    out_d = out_q;
    if (issue && !done_ok)      out_d = out_q + 1'b1;
    else if (!issue && done_ok) out_d = out_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= CH_IDLE;
      ptr_q    <= '0;
      dep_on_q <= 1'b0;
      out_q    <= '0;
    end else begin
      st_q     <= st_d;
      ptr_q    <= ptr_d;
      dep_on_q <= dep_on_d;
      out_q    <= out_d;
    end
  end
endmodule

// File: rtl/ctl_regs.sv
module ctl_regs
  import cmd_seq_pkg::*;
#(
  parameter int unsigned MST_ID_W = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                csr_wr,
  input  logic [CS_CSR_W-1:0] csr_wdata,
  input  logic                run_end,
  input  logic                irq_en,
  input  logic                irq_clr,
  output logic                start,
  output logic                run_on,
  output logic                loop_on,
  output logic                loop_at_start,
  output logic [CS_CSR_W-1:0] csr_rdata,
  output logic                irq
);
  localparam logic [2:0] ID_CODE = (MST_ID_W <= 1) ? 3'd0 : 3'(MST_ID_W - 1);

  logic en_q, en_d, loop_q, loop_d, irq_q, irq_d;

  assign start         = csr_wr && csr_wdata[CS_EN_BIT] && !en_q;
  assign loop_at_start = csr_wr ? csr_wdata[CS_LOOP_BIT] : loop_q;

  always_comb begin
    en_d = en_q;
    if (start)        en_d = 1'b1;
    else if (run_end) en_d = 1'b0;

    loop_d = loop_q;
    if (csr_wr) loop_d = csr_wdata[CS_LOOP_BIT];

    irq_d = irq_q;
    if (run_end && irq_en) irq_d = 1'b1;
    else if (irq_clr)      irq_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      loop_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      en_q   <= en_d;
      loop_q <= loop_d;
      irq_q  <= irq_d;
    end
  end

  assign run_on    = en_q;
  assign loop_on   = loop_q;
  assign irq       = irq_q;
  assign csr_rdata = {CS_REV, ID_CODE, en_q, loop_q, {CS_RSV_W{1'b0}}};
endmodule

// File: rtl/cmd_seq_top.sv
module cmd_seq_top
  import cmd_seq_pkg::*;
#(
  parameter int unsigned MST_ID_W = 4,
  parameter int unsigned MAX_OUT  = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                csr_wr,
  input  logic [CS_CSR_W-1:0] csr_wdata,
  output logic [CS_CSR_W-1:0] csr_rdata,
  input  logic                irq_en,
  input  logic                irq_clr,
  output logic                irq,
  input  logic                cmd_we,
  input  logic                cmd_bank,
  input  logic [CS_IDX_W-1:0] cmd_addr,
  input  logic [CS_ENT_W-1:0] cmd_wdata,
  output logic                wr_cmd_vld,
  input  logic                wr_cmd_rdy,
  output logic [CS_IDX_W-1:0] wr_cmd_idx,
  output logic [CS_PAY_W-1:0] wr_cmd_payload,
  input  logic                wr_done,
  input  logic [CS_IDX_W-1:0] wr_done_idx,
  output logic                rd_cmd_vld,
  input  logic                rd_cmd_rdy,
  output logic [CS_IDX_W-1:0] rd_cmd_idx,
  output logic [CS_PAY_W-1:0] rd_cmd_payload,
  input  logic                rd_done
);
  localparam int unsigned N_CH = 2;

  logic start, run_on, loop_on, loop_at_start, run_end;
  logic [CS_DEPTH-1:0] wr_cmp;

  cmd_entry_t          ent   [N_CH];
  logic [CS_PTR_W-1:0] ptr   [N_CH];
  logic [CS_DEPTH-1:0] dvec  [N_CH];
  logic                vld   [N_CH];
  logic                rdy   [N_CH];
  logic                done  [N_CH];
  logic                issue [N_CH];
  logic                fin   [N_CH];

  assign rdy[0]  = wr_cmd_rdy;
  assign rdy[1]  = rd_cmd_rdy;
  assign done[0] = wr_done;
  assign done[1] = rd_done;
  assign dvec[0] = '1;
  assign dvec[1] = wr_cmp;
  assign run_end = fin[0] && fin[1];

  ctl_regs #(.MST_ID_W(MST_ID_W)) i_ctl (
    .clk, .rst_n, .csr_wr, .csr_wdata, .run_end, .irq_en, .irq_clr,
    .start, .run_on, .loop_on, .loop_at_start, .csr_rdata, .irq
  );

  for (genvar g = 0; g < N_CH; g++) begin : g_ch
    logic st_we;
    assign st_we = cmd_we && !run_on && (cmd_bank == 1'(g));

    cmd_store i_store (
      .clk, .rst_n,
      .we    (st_we),
      .waddr (cmd_addr),
      .wdata (cmd_entry_t'(cmd_wdata)),
      .raddr (ptr[g]),
      .rdata (ent[g])
    );

    cmd_chan #(.MAX_OUT(MAX_OUT), .DEP_EN(g == 1)) i_chan (
      .clk, .rst_n,
      .start,
      .loop_on,
      .loop_at_start,
      .release_i (run_end),
      .entry     (ent[g]),
      .dep_vec   (dvec[g]),
      .rdy       (rdy[g]),
      .done      (done[g]),
      .ptr       (ptr[g]),
      .vld       (vld[g]),
      .issue     (issue[g]),
      .fin       (fin[g])
    );
  end

  cmp_track i_cmp (
    .clk, .rst_n,
    .clr_all   (start),
    .issue     (issue[0]),
    .issue_idx (ptr[0][CS_IDX_W-1:0]),
    .done      (wr_done),
    .done_idx  (wr_done_idx),
    .cmp_vec   (wr_cmp)
  );

  assign wr_cmd_vld     = vld[0];
  assign wr_cmd_idx     = ptr[0][CS_IDX_W-1:0];
  assign wr_cmd_payload = ent[0].payload;
  assign rd_cmd_vld     = vld[1];
  assign rd_cmd_idx     = ptr[1][CS_IDX_W-1:0];
  assign rd_cmd_payload = ent[1].payload;
endmodule

// File: rtl/cmd_seq_chk.sv
module cmd_seq_chk
  import cmd_seq_pkg::*;
(
  input logic                clk,
  input logic                rst_n,
  input logic                csr_wr,
  input logic [CS_CSR_W-1:0] csr_rdata,
  input logic                irq,
  input logic                wr_cmd_vld,
  input logic                wr_cmd_rdy,
  input logic [CS_IDX_W-1:0] wr_cmd_idx,
  input logic [CS_PAY_W-1:0] wr_cmd_payload,
  input logic                rd_cmd_vld
);
  // R1
  rev_rsv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_rdata[31:24] == CS_REV) && (csr_rdata[CS_RSV_W-1:0] == '0));

  // R3
  start_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(csr_rdata[CS_EN_BIT]) |-> $past(csr_wr));

  // R3
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !csr_rdata[CS_EN_BIT] |-> (!wr_cmd_vld && !rd_cmd_vld));

  // R4
  wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_cmd_vld && !wr_cmd_rdy) |=>
      (wr_cmd_vld && $stable(wr_cmd_idx) && $stable(wr_cmd_payload)));

  // R9
  irq_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $fell(csr_rdata[CS_EN_BIT]));
endmodule

bind cmd_seq_top cmd_seq_chk i_cmd_seq_chk (
  .clk, .rst_n, .csr_wr, .csr_rdata, .irq,
  .wr_cmd_vld, .wr_cmd_rdy, .wr_cmd_idx, .wr_cmd_payload, .rd_cmd_vld
);

// File: tb/test_cmd_seq_top.sv
module test_cmd_seq_top;
  logic        clk, rst_n;
  logic        csr_wr;
  logic [31:0] csr_wdata, csr_rdata;
  logic        irq_en, irq_clr, irq;
  logic        cmd_we, cmd_bank;
  logic [3:0]  cmd_addr;
  logic [21:0] cmd_wdata;
  logic        wr_cmd_vld, wr_cmd_rdy, wr_done;
  logic [3:0]  wr_cmd_idx, wr_done_idx;
  logic [15:0] wr_cmd_payload;
  logic        rd_cmd_vld, rd_cmd_rdy, rd_done;
  logic [3:0]  rd_cmd_idx;
  logic [15:0] rd_cmd_payload;

  int checks = 0, failures = 0;
  int cyc = 0;
  int wr_cnt, rd_cnt, wr_lat;
  int rd_first_cyc, wr_done2_cyc, rd_at_wr7;
  logic [15:0] wr_log [64];
  logic [15:0] rd_log [64];
  logic [7:0]  dq_v;
  logic [3:0]  dq_i [8];
  logic        rd_prev;

  cmd_seq_top i_cmd_seq_top (
    .clk, .rst_n, .csr_wr, .csr_wdata, .csr_rdata, .irq_en, .irq_clr, .irq,
    .cmd_we, .cmd_bank, .cmd_addr, .cmd_wdata,
    .wr_cmd_vld, .wr_cmd_rdy, .wr_cmd_idx, .wr_cmd_payload, .wr_done, .wr_done_idx,
    .rd_cmd_vld, .rd_cmd_rdy, .rd_cmd_idx, .rd_cmd_payload, .rd_done
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // stimulus/expected pairs for control word writes while idle: R1, R2
  localparam logic [63:0] VEC [6] = '{
    {32'h0008_0000, 32'h2068_0000},
    {32'hFFE7_FFFF, 32'h2060_0000},
    {32'h0007_FFFF, 32'h2060_0000},
    {32'hFF08_0000, 32'h2068_0000},
    {32'h00E8_0000, 32'h2068_0000},
    {32'h0000_0000, 32'h2060_0000}
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic finish_tb();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  // completion agent and issue monitor
  initial begin
    dq_v = '0; rd_prev = 1'b0;
    for (int k = 0; k < 8; k++) dq_i[k] = '0;
    wr_done = 1'b0; wr_done_idx = '0; rd_done = 1'b0;
    wr_cmd_rdy = 1'b1; rd_cmd_rdy = 1'b1;
    forever begin
      @(negedge clk);
      cyc++;
      for (int k = 7; k > 0; k--) begin
        dq_v[k] = dq_v[k-1];
        dq_i[k] = dq_i[k-1];
      end
      dq_v[0] = wr_cmd_vld && wr_cmd_rdy;
      dq_i[0] = wr_cmd_idx;
      wr_done     = dq_v[wr_lat];
      wr_done_idx = dq_i[wr_lat];
      if (wr_done && wr_done_idx == 4'd2 && wr_done2_cyc < 0) wr_done2_cyc = cyc;
      rd_done = rd_prev;
      rd_prev = rd_cmd_vld && rd_cmd_rdy;
      if (wr_cmd_vld && wr_cmd_rdy) begin
        if (wr_cnt < 64) wr_log[wr_cnt] = wr_cmd_payload;
        if (wr_cmd_idx == 4'd7 && rd_at_wr7 < 0) rd_at_wr7 = rd_cnt;
        wr_cnt++;
      end
      if (rd_cmd_vld && rd_cmd_rdy) begin
        if (rd_cnt < 64) rd_log[rd_cnt] = rd_cmd_payload;
        if (rd_cnt == 0) rd_first_cyc = cyc;
        rd_cnt++;
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=hung expected=finish");
    finish_tb();
  end

  task automatic clear_logs();
    wr_cnt = 0; rd_cnt = 0;
    rd_first_cyc = -1; wr_done2_cyc = -1; rd_at_wr7 = -1;
  endtask

  task automatic csr_write(input logic [31:0] d);
    @(negedge clk);
    csr_wr = 1'b1; csr_wdata = d;
    @(negedge clk);
    csr_wr = 1'b0; csr_wdata = '0;
  endtask

  task automatic mem_write(input logic b, input int a, input logic [21:0] d);
    @(negedge clk);
    cmd_we = 1'b1; cmd_bank = b; cmd_addr = 4'(a); cmd_wdata = d;
    @(negedge clk);
    cmd_we = 1'b0;
  endtask

  task automatic wipe_lists();
    for (int a = 0; a < 16; a++) begin
      mem_write(1'b0, a, '0);
      mem_write(1'b1, a, '0);
    end
  endtask

  function automatic logic [21:0] ent(input bit v, input bit de, input int di,
                                      input logic [15:0] p);
    return {v, de, 4'(di), p};
  endfunction

  task automatic wait_end(input string req);
    int n = 0;
    while (csr_rdata[20] && n < 3000) begin
      @(negedge clk);
      n++;
    end
    #1;
    chk(!csr_rdata[20], req, csr_rdata, 32'h0);
  endtask

  initial begin
    rst_n = 1'b0; csr_wr = 1'b0; csr_wdata = '0; irq_en = 1'b1; irq_clr = 1'b0;
    cmd_we = 1'b0; cmd_bank = 1'b0; cmd_addr = '0; cmd_wdata = '0; wr_lat = 1;
    clear_logs();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset value
    chk(csr_rdata == 32'h2060_0000, "R1 reset", csr_rdata, 32'h2060_0000);
    chk(!irq && !wr_cmd_vld && !rd_cmd_vld, "R3 reset idle",
        {irq, wr_cmd_vld, rd_cmd_vld}, 0);

    for (int v = 0; v < 6; v++) begin
      csr_write(VEC[v][63:32]);
      chk(csr_rdata == VEC[v][31:0], "R1/R2 csr vector", csr_rdata, VEC[v][31:0]);
    end

    // single pass, order and end of list: R3 R4 R5 R9 R10
    for (int i = 0; i < 3; i++) mem_write(1'b0, i, ent(1, 0, 0, 16'hA000 + 16'(i)));
    mem_write(1'b1, 0, ent(1, 0, 0, 16'hB000));
    mem_write(1'b1, 1, ent(1, 0, 0, 16'hB001));
    wr_lat = 6;
    clear_logs();
    csr_write(32'h0010_0000);
    chk(csr_rdata[20], "R3 busy bit", csr_rdata, 32'h0010_0000);
    mem_write(1'b0, 3, ent(1, 0, 0, 16'hDEAD));
    csr_write(32'h0010_0000);
    wait_end("R3 self clear");
    chk(wr_cnt == 3, "R10 store write ignored while busy", wr_cnt, 3);
    chk(rd_cnt == 2, "R5 read list length", rd_cnt, 2);
    for (int i = 0; i < 3; i++)
      chk(wr_log[i] == 16'hA000 + 16'(i), "R4 write order", wr_log[i], 16'hA000 + i);
    chk(rd_log[1] == 16'hB001, "R4 read order", rd_log[1], 16'hB001);
    chk(irq, "R9 irq raised", irq, 1);
    @(negedge clk);
    irq_clr = 1'b1;
    @(negedge clk);
    irq_clr = 1'b0;
    chk(!irq, "R9 irq cleared", irq, 0);

    // dependency honoured: R6
    wipe_lists();
    for (int i = 0; i < 4; i++) mem_write(1'b0, i, ent(1, 0, 0, 16'h1000 + 16'(i)));
    mem_write(1'b1, 0, ent(1, 1, 2, 16'hC000));
    mem_write(1'b1, 1, ent(1, 0, 0, 16'hC001));
    clear_logs();
    csr_write(32'h0010_0000);
    wait_end("R6 run end");
    chk(wr_done2_cyc > 0 && rd_first_cyc > wr_done2_cyc, "R6 read after write 2",
        rd_first_cyc, wr_done2_cyc + 1);
    chk(rd_cnt == 2, "R6 reads issued", rd_cnt, 2);

    // looping: R7 R8
    wipe_lists();
    for (int i = 0; i < 8; i++) mem_write(1'b0, i, ent(1, 0, 0, 16'h2000 + 16'(i)));
    mem_write(1'b1, 0, ent(1, 1, 2, 16'hE000));
    clear_logs();
    csr_write(32'h0018_0000);
    repeat (60) @(negedge clk);
    #1;
    chk(rd_first_cyc > 0 && rd_first_cyc < wr_done2_cyc, "R7 dependency ignored",
        rd_first_cyc, wr_done2_cyc);
    chk(rd_at_wr7 >= 3, "R7 independent wrap", rd_at_wr7, 3);
    chk(csr_rdata[20], "R7 still running", csr_rdata, 32'h0018_0000);
    csr_write(32'h0000_0000);
    chk(csr_rdata[20:19] == 2'b10, "R2 loop cleared while busy", csr_rdata, 32'h0010_0000);
    wait_end("R8 stops after loop clear");
    chk(wr_cnt % 8 == 0 && wr_cnt > 8, "R8 whole write passes", wr_cnt, 16);
    chk(irq, "R9 irq after loop run", irq, 1);
    @(negedge clk);
    irq_clr = 1'b1;
    @(negedge clk);
    irq_clr = 1'b0;

    // full list without terminator, irq disabled: R5 R9
    wipe_lists();
    for (int i = 0; i < 16; i++) mem_write(1'b1, i, ent(1, 0, 0, 16'h3000 + 16'(i)));
    irq_en = 1'b0;
    clear_logs();
    csr_write(32'h0010_0000);
    wait_end("R5 full list end");
    chk(rd_cnt == 16, "R5 sixteen entries", rd_cnt, 16);
    chk(rd_log[15] == 16'h300F, "R4 last payload", rd_log[15], 16'h300F);
    chk(wr_cnt == 0, "R5 empty write list", wr_cnt, 0);
    chk(!irq, "R9 irq masked", irq, 0);

    finish_tb();
  end
endmodule